// File: doc/BRIEF.md
# Line Voltage Polarity Monitor

This block sits behind a line-voltage converter. It turns each signed voltage sample into an 8-bit status level that software can read. The level is two's complement with 1 V per count, and it is meaningful whether the line is on-hook or off-hook. Its top bit tells which way TIP and RING are polarised. A new level is taken only on the converter's sample-valid strobe. Between strobes the last level is held.

By default, small readings are squashed to zero: any sample from -3 to +3 inclusive publishes as 0. A control bit turns this band off so that small readings pass unchanged. A true 0 V input still reads 0 either way.

The block watches the top bit of the published level and latches a sticky event flag on every change, in either direction. Software reads the flag and clears it by writing 0. An active-low interrupt line is pulled low while the flag is pending and both the global enable and the polarity mask are set. Software reaches all of this through a small register port with a combinational read path.

Top module: `lvmon_top`

## Requirements
- R1: After reset the level reads 0, the control register reads 0, the event flag reads 0 and `irq_n` is high.
- R2: The level register takes a new value only in a cycle where `smp_valid` is high. It holds while `smp_valid` is low, whatever `smp_data` does.
- R3: With control bit 2 (squash-off) at 0, a sample whose signed value lies between -3 and +3 inclusive publishes as 0x00. Any other sample publishes unchanged.
- R4: With control bit 2 at 1, every sample publishes unchanged, including values from -3 to +3. An input of 0 reads 0x00.
- R5: The event flag (address 2, bit 0) becomes 1 one clock after the published level's bit 7 changes, for a change in either direction. It is not raised when bit 7 keeps its value.
- R6: A write of 0 to address 2 bit 0 clears the flag on that clock edge. A write of 1 leaves the flag unchanged.
- R7: If a clear write and a bit-7 change land on the same clock edge, the flag ends up set.
- R8: `irq_n` is low exactly while the flag is 1, control bit 0 (global enable) is 1 and control bit 1 (polarity mask) is 1.
- R9: Register map:
  - Address 0 returns the level and ignores writes.
  - Address 1 holds control bits [2:0] and returns zeros above them.
  - Address 2 returns the flag in bit 0.
  - Address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 8 | Signed line-voltage sample, 1 V per count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Active-low polarity interrupt |

## Verification
The assertions assume that `smp_valid`, `smp_data` and the register port are steady and known at each rising edge. They also assume that a clear write is a single-cycle strobe decoded at address 2. The bench changes these inputs only on falling edges and holds each write for exactly one cycle.

The bench sweeps all 256 sample codes, once with squashing on and once with it off. For each code it predicts the published level and the sign-change flag arithmetically from the previous expected level. It then walks all four enable combinations and forces the same-edge collision between a clear and a sign change.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_EVENT = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    // Packed LSB-first: gie is bit 0, pmask bit 1, sq_off bit 2.
    typedef struct packed {
        logic sq_off;
        logic pmask;
        logic gie;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lvmon_publish.sv
module lvmon_publish #(
    parameter int unsigned W    = 8,
    parameter int unsigned ZLIM = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         sq_off,
    output logic [W-1:0] level_o
);
    localparam logic signed [W-1:0] LIM_POS = W'(ZLIM);
    localparam logic signed [W-1:0] LIM_NEG = -LIM_POS;

    typedef struct packed {
        logic [W-1:0] level;
    } st_t;

    st_t  st_d, st_q;
    logic in_band;
    logic [W-1:0] shaped;

    always_comb begin
        in_band = ($signed(smp_data) >= LIM_NEG) && ($signed(smp_data) <= LIM_POS);
        shaped  = (in_band && !sq_off) ? '0 : smp_data;
        st_d    = st_q;
        if (smp_valid) begin
            st_d.level = shaped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(level_o));
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && sq_off) |=> (level_o == $past(smp_data)));
    a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !sq_off && ($signed(smp_data) > -4) && ($signed(smp_data) < 4))
        |=> (level_o == '0));
endmodule

// File: rtl/lvmon_polarity.sv
module lvmon_polarity (
    input  logic clk,
    input  logic rst_n,
    input  logic sign_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic prev_sign;
        logic flag;
    } st_t;

    st_t  st_d, st_q;
    logic flip;

    always_comb begin
        flip           = sign_i ^ st_q.prev_sign;
        st_d.prev_sign = sign_i;
        // A fresh reversal overrides a clear on the same edge.
        st_d.flag      = flip | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_i != st_q.prev_sign) |=> flag_o);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (sign_i == st_q.prev_sign)) |=> !flag_o);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && (sign_i == st_q.prev_sign)) |=> !flag_o);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (sign_i != st_q.prev_sign)) |=> flag_o);
endmodule

// File: rtl/lvmon_regs.sv
module lvmon_regs
    import lvmon_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      level_i,
    input  logic              flag_i,
    output logic [W-1:0]      rdata_o,
    output ctrl_t             ctrl_o,
    output logic              clr_o
);
    typedef struct packed {
        ctrl_t ctrl;
    } st_t;

    st_t      st_d, st_q;
    reg_sel_e sel;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[W-1:CTRL_W];

    always_comb begin
        sel  = reg_sel_e'(addr_i);
        st_d = st_q;
        if (wr_i && sel == SEL_CTRL) begin
            st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    always_comb begin
        clr_o = wr_i && (sel == SEL_EVENT) && !wdata_i[0];
    end

    always_comb begin
        unique case (sel)
            SEL_LEVEL: rdata_o = level_i;
            SEL_CTRL:  rdata_o = {{(W-CTRL_W){1'b0}}, st_q.ctrl};
            SEL_EVENT: rdata_o = {{(W-1){1'b0}}, flag_i};
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

    a_r9_ctrl_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd1) |=> (ctrl_o == ctrl_t'($past(wdata_i[CTRL_W-1:0]))));
    a_r9_ctrl_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == 2'd1) |=> $stable(ctrl_o));
endmodule

// File: rtl/lvmon_top.sv
module lvmon_top
    import lvmon_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned ZLIM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [W-1:0]      smp_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq_n
);
    ctrl_t        ctrl;
    logic [W-1:0] level;
    logic         flag;
    logic         clr;

    lvmon_publish #(.W(W), .ZLIM(ZLIM)) publish_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .sq_off    (ctrl.sq_off),
        .level_o   (level)
    );

    lvmon_polarity polarity_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sign_i (level[W-1]),
        .clr_i  (clr),
        .flag_o (flag)
    );

    lvmon_regs #(.W(W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .level_i (level),
        .flag_i  (flag),
        .rdata_o (reg_rdata),
        .ctrl_o  (ctrl),
        .clr_o   (clr)
    );

    always_comb begin
        irq_n = ~(flag & ctrl.gie & ctrl.pmask);
    end

    a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.gie && ctrl.pmask) |-> irq_n);
    a_r8_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> irq_n);
endmodule

// File: tb/lvmon_top_tb_top.sv
module lvmon_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int vectors = 0;
    int fails = 0;
    logic [7:0] exp_level = '0;
    logic       exp_flag = 1'b0;
    logic       exp_gie = 1'b0;
    logic       exp_pm = 1'b0;

    always #5 clk = ~clk;

    lvmon_top dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_ctrl(input logic sq, input logic pm, input logic gie);
        wr(2'd1, {5'b0, sq, pm, gie});
        exp_gie = gie; exp_pm = pm;
    endtask

    task automatic check_irq(input string req);
        check(req, int'(irq_n), int'(!(exp_flag && exp_gie && exp_pm)));
    endtask

    // Strobe one sample, check the level, then the flag one clock later.
    task automatic apply(input int v, input logic sq, input string req_lvl);
        logic [7:0] nl;
        logic       chg;
        logic [7:0] r;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v[7:0];
        @(negedge clk);
        smp_valid = 1'b0;
        nl  = (!sq && v >= -3 && v <= 3) ? 8'h00 : v[7:0];
        chg = nl[7] != exp_level[7];
        exp_level = nl;
        rd(2'd0, r);
        check(req_lvl, int'(r), int'(exp_level));
        @(negedge clk);
        exp_flag = exp_flag | chg;
        rd(2'd2, r);
        check("R5 flag after sample", int'(r), int'({7'b0, exp_flag}));
    endtask

    task automatic clear_flag();
        logic [7:0] r;
        wr(2'd2, 8'h00);
        exp_flag = 1'b0;
        rd(2'd2, r);
        check("R6 clear by writing 0", int'(r), 0);
        check_irq("R8 irq after clear");
    endtask

    initial begin
        logic [7:0] r;
        #200;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); check("R1 level", int'(r), 0);
        rd(2'd1, r); check("R1 ctrl", int'(r), 0);
        rd(2'd2, r); check("R1 flag", int'(r), 0);
        check("R1 irq_n", int'(irq_n), 1);

        // R9 register map
        wr(2'd0, 8'h5A);
        rd(2'd0, r); check("R9 level ignores writes", int'(r), 0);
        wr(2'd1, 8'hFF);
        rd(2'd1, r); check("R9 ctrl readback", int'(r), 8'h07);
        rd(2'd3, r); check("R9 spare reads zero", int'(r), 0);
        set_ctrl(1'b0, 1'b0, 1'b0);
        rd(2'd1, r); check("R9 ctrl cleared", int'(r), 0);

        // R2 hold without strobe
        apply(50, 1'b0, "R2 strobed level");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            smp_data = 8'(-77 + k * 31);
            @(negedge clk);
            rd(2'd0, r); check("R2 hold without strobe", int'(r), int'(exp_level));
        end

        // R3 / R4 full sweeps with interrupt enabled
        for (int sq = 0; sq < 2; sq++) begin
            set_ctrl(sq[0], 1'b1, 1'b1);
            for (int v = -128; v < 128; v++) begin
                apply(v, sq[0], sq[0] ? "R4 pass-through level" : "R3 squashed level");
                check_irq("R8 irq after sample");
                if (exp_flag) clear_flag();
            end
        end

        // R8 enable combinations with a pending flag
        apply((exp_level[7]) ? 100 : -100, 1'b1, "R4 level");
        for (int c = 0; c < 4; c++) begin
            set_ctrl(1'b1, c[1], c[0]);
            check_irq("R8 enable combination");
        end

        // R6 writing 1 has no effect
        set_ctrl(1'b1, 1'b1, 1'b1);
        wr(2'd2, 8'h01);
        rd(2'd2, r); check("R6 write 1 keeps set flag", int'(r), int'({7'b0, exp_flag}));
        clear_flag();
        wr(2'd2, 8'h01);
        rd(2'd2, r); check("R6 write 1 keeps clear flag", int'(r), 0);

        // R7 clear and reversal on the same edge
        apply((exp_level[7]) ? 90 : -90, 1'b1, "R4 level");
        @(negedge clk);
        smp_valid = 1'b1; smp_data = (exp_level[7]) ? 8'd60 : 8'hC4;
        @(negedge clk);
        smp_valid = 1'b0;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        exp_level = smp_data;
        rd(2'd2, r); check("R7 set wins over clear", int'(r), 1);
        exp_flag = 1'b1;
        check_irq("R8 irq after collision");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule